// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is one DMA channel. Software programs a start address, a block-control word and a channel-control word, then sets the busy bit. The engine moves 32-bit words between a word-wide memory port and a streaming device port. It has four operating modes:

- a counted block transfer in either direction;
- a walk of a linked list of command packets, sent from memory to the device;
- an ordering-table clear, which writes a reverse-linked chain of empty entries downward through memory;
- a completion stage that drops the busy bits and, when gated on, raises a flag and a one-cycle interrupt request.

The memory port carries one access at a time. A request holds its address, write enable and write data until the memory answers with ready. The device port has two streams: an outbound word with valid/ready, and an inbound word that the engine pulls with ready when the device shows valid. Register writes use a select code: 0 selects the start address, 1 the block-control word, 2 the channel-control word and 3 the interrupt-control word. A channel index parameter picks which bits of the shared interrupt-control word belong to this engine.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, all four registers read zero, `mem_req`, `dev_out_valid`, `dev_in_ready` and `dma_irq` are low.
- R2: A transfer starts when control bit 24 is set and either the sync field (control bits 10:9) is nonzero or control bit 28 is set. Bit 24 with sync 0 and bit 28 clear starts nothing: no memory access, no device handshake, and bit 24 stays set.
- R3: With sync 0 or 1, control bit 0 = 1 sends words to the device. Each word is read from memory in turn and handed out in order, with `dev_out_data` held while valid waits for ready. With sync 0 the word count is block bits 15:0. With sync 1 it is the product of block bits 15:0 and 31:16. A zero field counts as 65536.
- R4: With sync 0 or 1, control bit 0 = 0 takes words from the device and writes them to memory, one per accepted device word, in arrival order.
- R5: Every memory address is 21 bits, word aligned, equal to the address masked with 0x1FFFFC. Control bit 1 = 0 steps +4 and = 1 steps -4, wrapping inside the 21-bit space.
- R6: With sync 2, each node is a header word. Bits 31:24 are the count of payload words at the following addresses, sent to the device in order. Bit 23 set ends the walk after that node. Otherwise the next header is read at header bits 23:0 masked with 0x1FFFFC.
- R7: With sync 3, the engine writes block bits 15:0 entries (zero means 65536) from the start address downward, whatever control bit 1 says. Each entry holds its own address minus 4, masked with 0x1FFFFC. The last entry holds 0x00FFFFFF.
- R8: At completion, control bits 24 and 28 clear. With sync 1, block bits 31:16 also clear, while bits 15:0 and the other modes leave the block word as written.
- R9: At completion, if interrupt-control bit (16+CH_IDX) and bit 23 are both set, flag bit (24+CH_IDX) sets and `dma_irq` pulses high for one cycle. Otherwise neither happens.
- R10: Writing 1 to a flag bit (30:24) of the interrupt-control word clears it. Writing 0 leaves it.
- R11: A memory request keeps address, write enable and write data stable until `mem_ready`. `mem_we` is only high together with `mem_req`.
- R12: Writes to the start-address, block-control and channel-control registers are ignored while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 block, 2 control, 3 interrupt control |
| reg_wdata | input | 32 | Register write data |
| base_q | output | 32 | Start-address register |
| blk_q | output | 32 | Block-control register |
| ctl_q | output | 32 | Channel-control register |
| irqc_q | output | 32 | Interrupt-control register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 21 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory completes the request |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_data | output | 32 | Outbound word |
| dev_out_ready | input | 1 | Device accepts outbound word |
| dev_in_data | input | 32 | Inbound word |
| dev_in_valid | input | 1 | Inbound word valid |
| dev_in_ready | output | 1 | Engine accepts inbound word |
| dma_irq | output | 1 | One-cycle interrupt request |

## Verification
The bench targets several corner cases, each with a visible failure mode:

- **Decrementing wrap:** a walk going down past address zero must land on 0x1FFFFC. A design that forgot the mask would fetch from a wrong word.
- **Linked list:** the list contains an empty node and a pointer with bits above the 21-bit space. A design that mishandled the zero count or the mask would stall or follow the wrong chain.
- **Ordering-table clear:** this runs once with a count field of zero. It must make exactly 65536 writes, ending with 0x00FFFFFF at 0x1C0000. An off-by-one count or a wrong end marker shows in the last write.
- **Gating and side effects:** the bench checks that a busy bit without trigger in sync 0 stays inert. It checks that register writes during a run change nothing, and that only sync 1 clears the upper block field. It checks that the flag and interrupt appear only when both enables are set.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 21;
    localparam int SPAN_W = 17;
    localparam int CNT_W  = 2 * SPAN_W - 1;
    localparam logic [ADDR_W-1:0] ADDR_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
    localparam logic [WORD_W-1:0] CHAIN_END = 32'h00FF_FFFF;

    // control-word and interrupt-word bit positions
    localparam int CTL_DIR   = 0;
    localparam int CTL_DOWN  = 1;
    localparam int CTL_SYNC  = 9;
    localparam int CTL_BUSY  = 24;
    localparam int CTL_TRIG  = 28;
    localparam int IRQ_EN0   = 16;
    localparam int IRQ_MASTR = 23;
    localparam int IRQ_FLAG0 = 24;
    localparam int IRQ_NCH   = 7;

    typedef enum logic [1:0] {
        XF_TO_DEV,
        XF_FROM_DEV,
        XF_LIST,
        XF_CLEAR
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_TAKE,
        ST_STORE,
        ST_HEAD
    } walk_state_e;

    typedef struct packed {
        xfer_kind_e              kind;
        logic                    step_down;
        logic [ADDR_W-1:0]       start_addr;
        logic [CNT_W-1:0]        words;
    } job_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] a);
        return a[ADDR_W-1:0] & ADDR_MASK;
    endfunction

    function automatic logic [SPAN_W-1:0] span(input logic [15:0] f);
        return (f == 16'h0) ? SPAN_W'(32'h10000) : SPAN_W'(f);
    endfunction

    function automatic logic [CNT_W-1:0] job_words(input logic [WORD_W-1:0] bc,
                                                   input logic [1:0] sync);
        logic [2*SPAN_W-1:0] prod;
        prod = (2*SPAN_W)'(span(bc[15:0])) * (2*SPAN_W)'(span(bc[31:16]));
        return (sync == 2'd1) ? prod[CNT_W-1:0] : CNT_W'(span(bc[15:0]));
    endfunction

    function automatic xfer_kind_e kind_of(input logic [WORD_W-1:0] ctl);
        case (ctl[CTL_SYNC +: 2])
            2'd2:    return XF_LIST;
            2'd3:    return XF_CLEAR;
            default: return ctl[CTL_DIR] ? XF_TO_DEV : XF_FROM_DEV;
        endcase
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_eng_pkg::*;
#(
    parameter int CH_IDX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              active,
    input  logic              done,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] blk_q,
    output logic [WORD_W-1:0] ctl_q,
    output logic [WORD_W-1:0] irqc_q,
    output logic              start,
    output job_t              job,
    output logic              irq_pulse
);

    logic             gate;
    logic [IRQ_NCH-1:0] flag_set, flag_clr;

    assign start = !active && ctl_q[CTL_BUSY] &&
                   ((ctl_q[CTL_SYNC +: 2] != 2'd0) || ctl_q[CTL_TRIG]);
    assign job.kind       = kind_of(ctl_q);
    assign job.step_down  = ctl_q[CTL_DOWN];
    assign job.start_addr = word_addr(base_q);
    assign job.words      = job_words(blk_q, ctl_q[CTL_SYNC +: 2]);

    assign gate     = irqc_q[IRQ_EN0 + CH_IDX] && irqc_q[IRQ_MASTR];
    assign flag_set = (done && gate) ? IRQ_NCH'(1) << CH_IDX : '0;
    assign flag_clr = (reg_we && reg_sel == 2'd3) ? reg_wdata[IRQ_FLAG0 +: IRQ_NCH] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            blk_q     <= '0;
            ctl_q     <= '0;
            irqc_q    <= '0;
            irq_pulse <= 1'b0;
        end else begin
            if (reg_we && !active) begin
                case (reg_sel)
                    2'd0:    base_q <= reg_wdata;
                    2'd1:    blk_q  <= reg_wdata;
                    2'd2:    ctl_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (reg_we && reg_sel == 2'd3)
                irqc_q[IRQ_MASTR:0] <= reg_wdata[IRQ_MASTR:0];
            irqc_q[IRQ_FLAG0 +: IRQ_NCH] <= (irqc_q[IRQ_FLAG0 +: IRQ_NCH] & ~flag_clr) | flag_set;
            if (done) begin
                ctl_q[CTL_BUSY] <= 1'b0;
                ctl_q[CTL_TRIG] <= 1'b0;
                if (ctl_q[CTL_SYNC +: 2] == 2'd1)
                    blk_q[31:16] <= 16'h0;
            end
            irq_pulse <= done && gate;
        end
    end

endmodule

// File: rtl/dma_walker.sv
module dma_walker
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              job,
    output logic              active,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              dev_out_valid,
    output logic [WORD_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic [WORD_W-1:0] dev_in_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready
);

    walk_state_e       st;
    xfer_kind_e        kind_q;
    logic              down_q;
    logic [ADDR_W-1:0] cur;
    logic [CNT_W-1:0]  left;
    logic [7:0]        pay;
    logic              end_q;
    logic [ADDR_W-1:0] next_q;
    logic [WORD_W-1:0] buf_q;
    logic              last_word;
    logic [ADDR_W-1:0] cur_step, cur_inc, cur_dec, hdr_next;

    assign last_word = (left == CNT_W'(1));
    assign cur_inc   = (cur + WORD_STEP) & ADDR_MASK;
    assign cur_dec   = (cur - WORD_STEP) & ADDR_MASK;
    assign cur_step  = down_q ? cur_dec : cur_inc;
    assign hdr_next  = word_addr({8'h0, mem_rdata[23:0]});

    assign active        = (st != ST_IDLE);
    assign mem_req       = (st == ST_FETCH) || (st == ST_STORE) || (st == ST_HEAD);
    assign mem_we        = (st == ST_STORE);
    assign mem_addr      = cur;
    assign mem_wdata     = (kind_q != XF_CLEAR) ? buf_q :
                           last_word ? CHAIN_END : WORD_W'(cur_dec);
    assign dev_out_valid = (st == ST_SEND);
    assign dev_out_data  = buf_q;
    assign dev_in_ready  = (st == ST_TAKE);

    always_comb begin
        case (st)
            ST_STORE: done = mem_ready && last_word;
            ST_SEND:  done = dev_out_ready &&
                             ((kind_q == XF_LIST) ? (pay == 8'd1 && end_q) : last_word);
            ST_HEAD:  done = mem_ready && mem_rdata[31:24] == 8'd0 && mem_rdata[23];
            default:  done = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            kind_q <= XF_TO_DEV;
            down_q <= 1'b0;
            cur    <= '0;
            left   <= '0;
            pay    <= '0;
            end_q  <= 1'b0;
            next_q <= '0;
            buf_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    kind_q <= job.kind;
                    down_q <= job.step_down || (job.kind == XF_CLEAR);
                    cur    <= job.start_addr;
                    left   <= job.words;
                    case (job.kind)
                        XF_TO_DEV:   st <= ST_FETCH;
                        XF_FROM_DEV: st <= ST_TAKE;
                        XF_LIST:     st <= ST_HEAD;
                        default:     st <= ST_STORE;
                    endcase
                end
                ST_FETCH: if (mem_ready) begin
                    buf_q <= mem_rdata;
                    st    <= ST_SEND;
                end
                ST_SEND: if (dev_out_ready) begin
                    if (kind_q == XF_LIST) begin
                        if (pay == 8'd1) begin
                            cur <= next_q;
                            st  <= end_q ? ST_IDLE : ST_HEAD;
                        end else begin
                            pay <= pay - 8'd1;
                            cur <= cur_inc;
                            st  <= ST_FETCH;
                        end
                    end else begin
                        left <= left - CNT_W'(1);
                        cur  <= cur_step;
                        st   <= last_word ? ST_IDLE : ST_FETCH;
                    end
                end
                ST_TAKE: if (dev_in_valid) begin
                    buf_q <= dev_in_data;
                    st    <= ST_STORE;
                end
                ST_STORE: if (mem_ready) begin
                    left <= left - CNT_W'(1);
                    cur  <= cur_step;
                    if (last_word)                st <= ST_IDLE;
                    else if (kind_q != XF_CLEAR)  st <= ST_TAKE;
                end
                ST_HEAD: if (mem_ready) begin
                    pay    <= mem_rdata[31:24];
                    end_q  <= mem_rdata[23];
                    next_q <= hdr_next;
                    if (mem_rdata[31:24] == 8'd0) begin
                        cur <= hdr_next;
                        if (mem_rdata[23]) st <= ST_IDLE;
                    end else begin
                        cur <= cur_inc;
                        st  <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int CH_IDX = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] base_q,
    output logic [31:0] blk_q,
    output logic [31:0] ctl_q,
    output logic [31:0] irqc_q,
    output logic        mem_req,
    output logic        mem_we,
    output logic [20:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        dev_out_valid,
    output logic [31:0] dev_out_data,
    input  logic        dev_out_ready,
    input  logic [31:0] dev_in_data,
    input  logic        dev_in_valid,
    output logic        dev_in_ready,
    output logic        dma_irq
);

    logic start, active, done;
    job_t job;

    dma_regs #(.CH_IDX(CH_IDX)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .active    (active),
        .done      (done),
        .base_q    (base_q),
        .blk_q     (blk_q),
        .ctl_q     (ctl_q),
        .irqc_q    (irqc_q),
        .start     (start),
        .job       (job),
        .irq_pulse (dma_irq)
    );

    dma_walker u_walk (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .job           (job),
        .active        (active),
        .done          (done),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_ready (dev_out_ready),
        .dev_in_data   (dev_in_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready)
    );

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
    parameter int CH_IDX = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [20:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready,
    input logic        dev_out_valid,
    input logic [31:0] dev_out_data,
    input logic        dev_out_ready,
    input logic        dev_in_ready,
    input logic [31:0] ctl_q,
    input logic [31:0] irqc_q,
    input logic        dma_irq
);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                                  (!mem_we || $stable(mem_wdata)));

    assert_we_with_req_R11: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    assert_one_port_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_req, dev_out_valid, dev_in_ready}) <= 1);

    assert_dev_hold_R3: assert property (@(posedge clk) disable iff (rst)
        dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

    assert_addr_align_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        dma_irq |-> $past(irqc_q[23] && irqc_q[16 + CH_IDX]));

    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (rst)
        dma_irq |-> irqc_q[24 + CH_IDX]);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (rst)
        dma_irq |-> !ctl_q[24] && !ctl_q[28]);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CH_IDX(CH_IDX)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .dev_out_valid (dev_out_valid),
    .dev_out_data  (dev_out_data),
    .dev_out_ready (dev_out_ready),
    .dev_in_ready  (dev_in_ready),
    .ctl_q         (ctl_q),
    .irqc_q        (irqc_q),
    .dma_irq       (dma_irq)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

    localparam int CH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] base_q, blk_q, ctl_q, irqc_q;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [20:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        dev_out_valid, dev_out_ready = 1'b0;
    logic [31:0] dev_out_data, dev_in_data;
    logic        dev_in_valid = 1'b0, dev_in_ready, dma_irq;

    logic [31:0] mem [0:1023];
    logic [31:0] outlog [0:63];
    int          out_n = 0, in_n = 0, wr_n = 0, irq_n = 0, act_n = 0, cyc = 0;
    logic [20:0] last_wa = '0;
    logic [31:0] last_wd = '0;
    bit          fast = 1'b0;
    int          checks = 0, fails = 0;

    always #5 clk = ~clk;

    dma_chan_engine #(.CH_IDX(CH)) dut_i (.*);

    assign mem_rdata   = mem[mem_addr[11:2]];
    assign dev_in_data = 32'hA000_0000 + 32'(in_n);

    always @(posedge clk) begin
        if (dev_out_valid && dev_out_ready) begin
            outlog[out_n % 64] <= dev_out_data;
            out_n <= out_n + 1;
        end
        if (dev_in_valid && dev_in_ready) in_n <= in_n + 1;
        if (mem_req && mem_we && mem_ready) begin
            wr_n    <= wr_n + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
        end
        if (dma_irq) irq_n <= irq_n + 1;
        if (mem_req || dev_in_ready || dev_out_valid) act_n <= act_n + 1;
    end

    always @(negedge clk) begin
        mem_ready     <= fast || ($urandom_range(0, 1) == 1);
        dev_out_ready <= fast || ($urandom_range(0, 2) != 0);
        dev_in_valid  <= fast || ($urandom_range(0, 1) == 1);
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp<=%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int idx);
        return 32'h5A00_0000 ^ (32'(idx) * 32'h0001_0203);
    endfunction

    function automatic logic [20:0] exp_addr(input logic [31:0] base, input int k,
                                              input bit down);
        logic [20:0] b;
        b = base[20:0] & 21'h1FFFFC;
        return down ? ((b - 21'(4 * k)) & 21'h1FFFFC) : ((b + 21'(4 * k)) & 21'h1FFFFC);
    endfunction

    // memory model stores are nonblocking everywhere in the bench
    always @(posedge clk)
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (ctl_q[24]);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_block(input logic [31:0] base, input int lo, input int hi,
                            input int sync, input bit dir, input bit down, input bit en,
                            input bit poke);
        int n, o0, i0, q0;
        logic [31:0] ctl;
        fill_mem();
        o0 = out_n; i0 = in_n; q0 = irq_n;
        n  = (sync == 1) ? lo * hi : lo;
        wr_reg(2'd3, {8'h0, en, 6'h0, en, 16'h0} | (32'h1 << (16 + CH)) * en);
        wr_reg(2'd0, base);
        wr_reg(2'd1, {16'(hi), 16'(lo)});
        ctl = (32'h1 << 24) | (32'(sync) << 9) | (32'(down) << 1) | 32'(dir) |
              ((sync == 0) ? 32'h1000_0000 : 32'h0);
        wr_reg(2'd2, ctl);
        if (poke) begin
            wr_reg(2'd0, 32'h1234_5678);
            wr_reg(2'd1, 32'h0000_0009);
        end
        wait_idle();
        for (int k = 0; k < n; k++) begin
            logic [20:0] a;
            a = exp_addr(base, k, down);
            if (dir) check(outlog[(o0 + k) % 64] == pat(int'(a[11:2])), "R3/R5 word to device",
                           outlog[(o0 + k) % 64], pat(int'(a[11:2])));
            else     check(mem[a[11:2]] == 32'hA000_0000 + 32'(i0 + k), "R4/R5 word to memory",
                           mem[a[11:2]], 32'hA000_0000 + 32'(i0 + k));
        end
        if (dir) check(out_n - o0 == n, "R3 word count", 32'(out_n - o0), 32'(n));
        else     check(in_n - i0 == n, "R4 word count", 32'(in_n - i0), 32'(n));
        check(ctl_q == (ctl & ~32'h1100_0000), "R8 busy and trigger cleared",
              ctl_q, ctl & ~32'h1100_0000);
        check(blk_q == ((sync == 1) ? 32'(lo) : {16'(hi), 16'(lo)}), "R8 block word",
              blk_q, (sync == 1) ? 32'(lo) : {16'(hi), 16'(lo)});
        if (poke) check(base_q == base, "R12 write during run ignored", base_q, base);
        check(irq_n - q0 == int'(en), "R9 interrupt pulse", 32'(irq_n - q0), 32'(en));
        check(irqc_q[24 + CH] == en, "R9 flag", 32'(irqc_q[24 + CH]), 32'(en));
        wr_reg(2'd3, 32'h1 << (24 + CH));
        check(irqc_q[30:24] == 7'h0, "R10 flag write-one clear", 32'(irqc_q[30:24]), 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(base_q == 0 && blk_q == 0 && ctl_q == 0 && irqc_q == 0, "R1 registers",
              base_q | blk_q | ctl_q | irqc_q, 32'h0);
        check(!mem_req && !dev_out_valid && !dev_in_ready && !dma_irq, "R1 idle ports",
              {28'h0, mem_req, dev_out_valid, dev_in_ready, dma_irq}, 32'h0);

        // R2: busy bit without trigger in sync 0 is inert
        begin
            int a0;
            a0 = act_n;
            wr_reg(2'd1, 32'h0000_0004);
            wr_reg(2'd2, 32'h0100_0001);
            repeat (20) @(negedge clk);
            check(act_n == a0, "R2 no activity without trigger", 32'(act_n - a0), 32'h0);
            check(ctl_q[24], "R2 busy bit stays set", 32'(ctl_q[24]), 32'h1);
            wr_reg(2'd2, 32'h0);
        end

        // directed: decrementing wrap through address zero, upper base bits ignored
        do_block(32'hFFE0_0004, 3, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R12 writes while running, R2 sync 1 starts without trigger
        do_block(32'h0000_0400, 4, 2, 1, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int t = 0; t < 6; t++) begin
            logic [31:0] b;
            b = 32'h0000_1000 + 32'($urandom_range(0, 200) * 4);
            do_block(b, $urandom_range(1, 6), $urandom_range(1, 3), $urandom_range(0, 1),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'b0);
        end

        // R6: three-node list, one empty node, pointer with out-of-range bits
        begin
            int o0;
            fill_mem();
            mem[64]  <= 32'h0260_0200;  // 2 payload words, next 0x600200 -> 0x200
            mem[65]  <= 32'h1111_0001;
            mem[66]  <= 32'h1111_0002;
            mem[128] <= 32'h0000_0300;  // empty node -> 0x300
            mem[192] <= 32'h0380_0000;  // 3 payload words, end marker
            mem[193] <= 32'h3333_0001;
            mem[194] <= 32'h3333_0002;
            mem[195] <= 32'h3333_0003;
            @(negedge clk);
            o0 = out_n;
            wr_reg(2'd0, 32'h0000_0100);
            wr_reg(2'd2, 32'h0100_0401);
            wait_idle();
            check(out_n - o0 == 5, "R6 payload count", 32'(out_n - o0), 32'd5);
            check(outlog[(o0 + 0) % 64] == 32'h1111_0001, "R6 word 0", outlog[(o0 + 0) % 64], 32'h1111_0001);
            check(outlog[(o0 + 1) % 64] == 32'h1111_0002, "R6 word 1", outlog[(o0 + 1) % 64], 32'h1111_0002);
            check(outlog[(o0 + 2) % 64] == 32'h3333_0001, "R6 word 2", outlog[(o0 + 2) % 64], 32'h3333_0001);
            check(outlog[(o0 + 4) % 64] == 32'h3333_0003, "R6 word 4", outlog[(o0 + 4) % 64], 32'h3333_0003);
            check(ctl_q[24] == 1'b0, "R8 list completion", 32'(ctl_q[24]), 32'h0);
        end

        // R7: short ordering-table clear, step bit ignored
        begin
            int n;
            n = $urandom_range(2, 9);
            fill_mem();
            wr_reg(2'd0, 32'h0000_0800);
            wr_reg(2'd1, 32'(n));
            wr_reg(2'd2, 32'h0100_0600);
            wait_idle();
            for (int k = 0; k < n; k++) begin
                logic [20:0] a;
                logic [31:0] e;
                a = exp_addr(32'h800, k, 1'b1);
                e = (k == n - 1) ? 32'h00FF_FFFF : 32'(exp_addr(32'h800, k + 1, 1'b1));
                check(mem[a[11:2]] == e, "R7 table entry", mem[a[11:2]], e);
            end
            check(mem[(32'h804 >> 2)] == pat(32'h804 >> 2), "R7 no upward write",
                  mem[32'h804 >> 2], pat(32'h804 >> 2));
            check(blk_q == 32'(n), "R8 block word kept", blk_q, 32'(n));
        end

        // R7: zero count field means 65536 entries
        begin
            int w0;
            fast = 1'b1;
            @(negedge clk);
            w0 = wr_n;
            wr_reg(2'd0, 32'h001F_FFFC);
            wr_reg(2'd1, 32'h0000_0000);
            wr_reg(2'd2, 32'h0100_0600);
            wait_idle();
            check(wr_n - w0 == 65536, "R7 zero count writes", 32'(wr_n - w0), 32'd65536);
            check(last_wa == 21'h1C_0000, "R7 last address", 32'(last_wa), 32'h1C_0000);
            check(last_wd == 32'h00FF_FFFF, "R7 end marker", last_wd, 32'h00FF_FFFF);
            fast = 1'b0;
        end

        summary();
        $finish;
    end

endmodule